// File: doc/BRIEF.md
# Split-Resolution DAC Code Sequencer

This block turns a 12-bit two's-complement actuator command into the two digital streams that a hybrid DAC needs. The eight upper bits, sign included, form a coarse word for an 8-bit current DAC. The four lower bits drive a one-bit DAC, one bit per PWM slot and most significant first. Over one sequence of four slots the fine path therefore adds a duty of 0, 25, 50, 75 or 100 percent to the coarse level. A fast enable marks each coarse update tick. A slot lasts a fixed number of those ticks, so a full 12-bit sample is replayed once per sequence.

The host writes codes whenever it likes. A written code waits in a shadow register and moves to the working register only at a sequence boundary, so one sequence never mixes two codes. A one-clock frame-start flag marks each new sequence. A parameter sets the resolution of the channel. An 8-bit channel ignores the four low bits of every code. A 10-bit channel, whose data the host left-aligns, ignores the two lowest bits.

Top module: `dac_split_seq`

## Requirements
- R1: `coarse_word` equals bits [11:4] of the applied code, passed on as a two's-complement value without change (code 0x800 gives 0x80, 0x7FF gives 0x7F, 0x000 gives 0x00).
- R2: Each sequence has four slots of `TICKS_PER_SLOT` fast ticks. During slot k (k = 0..3), `fine_bit` carries bit 3-k of the applied code, so bit 3 comes first and bit 0 last.
- R3: A sequence lasts exactly 4 x `TICKS_PER_SLOT` fast ticks. `frame_start` is high for exactly one clock, in the cycle after the fast tick that ends the previous sequence.
- R4: A written code is applied only from the next sequence start. During a sequence, `coarse_word` and the serialised fine bits come from a single code.
- R5: When several writes land within one sequence, the last of them is applied at the next boundary.
- R6: A write in the same cycle as the fast tick that ends a sequence is applied to the sequence that starts at that tick.
- R7: With no new write, the previous code is replayed unchanged in every following sequence.
- R8: With `RES_BITS` = 8 the four low code bits are treated as zero, so `fine_bit` stays 0. With `RES_BITS` = 10 the two lowest bits are treated as zero, so `fine_bit` is 0 in slots 2 and 3.
- R9: A synchronous active-low reset clears the shadow and working codes to 0x000 and holds `coarse_word`, `fine_bit` and `frame_start` at 0. The first sequence starts at the first fast tick after reset.
- R10: Clocks with `fast_en` low change neither `fine_bit` nor `coarse_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_en | input | 1 | Coarse update tick enable, high one clock per tick |
| wr_valid | input | 1 | Strobe: `wr_code` holds a new command |
| wr_code | input | 12 | Two's-complement command code |
| coarse_word | output | 8 | Word for the coarse current DAC (code bits [11:4]) |
| fine_bit | output | 1 | Serial bit for the one-bit DAC |
| frame_start | output | 1 | One-clock flag at the start of each sequence |

## Verification
A host write and the shadow-to-working transfer at a sequence boundary can fall in the same cycle. The bench provokes this by counting fast ticks from a frame-start flag and raising the write strobe exactly on the tick that ends the sequence. That write must already appear on the coarse word in the cycle where the new frame-start flag is high. A second case places a write one clock before that tick, on a cycle without a fast tick, and a third places two writes in one sequence. In both cases a scoreboard fed by the driver judges which code each sequence carries, for all three resolution variants.

// File: rtl/dac_seq_pkg.sv
// Package: shared helpers for the split-resolution DAC sequencer.
// Assumes code widths of at most 32 bits.
package dac_seq_pkg;

    // Builds a mask that keeps the res_bits upper bits of a code_w-bit code.
    function automatic logic [31:0] keep_mask(int unsigned code_w, int unsigned res_bits);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < 32; i++) begin
            if ((i < int'(code_w)) && (i >= int'(code_w) - int'(res_bits)))
                m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/dac_code_regs.sv
// dac_code_regs: shadow and working registers for the command code.
// Every write is masked to the channel resolution and stored in the shadow.
// At a sequence load the working register takes the shadow value. A write in
// the load cycle bypasses the shadow. Assumes RES_BITS <= CODE_W.
module dac_code_regs #(
    parameter int unsigned CODE_W   = 12,
    parameter int unsigned RES_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              seq_load,
    output logic [CODE_W-1:0] work_code
);
    import dac_seq_pkg::*;

    localparam logic [CODE_W-1:0] KEEP = CODE_W'(keep_mask(CODE_W, RES_BITS));

    logic [CODE_W-1:0] masked_code;
    logic [CODE_W-1:0] shadow_q;

    // Drop the low bits that the channel cannot resolve.
    assign masked_code = wr_code & KEEP;

    // Hold the most recent host write until the next boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (wr_valid)
            shadow_q <= masked_code;
    end

    // Load the working code at a sequence boundary, with write bypass.
    always_ff @(posedge clk) begin
        if (!rst_n)
            work_code <= '0;
        else if (seq_load)
            work_code <= wr_valid ? masked_code : shadow_q;
    end

endmodule

// File: rtl/dac_slot_timer.sv
// dac_slot_timer: counts fast ticks into slots and slots into sequences.
// Flags the sequence-ending tick (seq_load) and registers a one-clock
// frame_start after it. After reset the counters sit at their last values,
// so the first fast tick starts a sequence. Assumes FINE_W >= 2.
module dac_slot_timer #(
    parameter int unsigned FINE_W         = 4,
    parameter int unsigned TICKS_PER_SLOT = 4,
    parameter int unsigned SLOT_W         = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_en,
    output logic              seq_load,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              frame_start
);
    localparam int unsigned       TICK_W     = (TICKS_PER_SLOT > 1) ? $clog2(TICKS_PER_SLOT) : 1;
    localparam logic [TICK_W-1:0] TICK_LAST  = TICK_W'(TICKS_PER_SLOT - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST  = SLOT_W'(FINE_W - 1);

    logic [TICK_W-1:0] tick_q;
    logic [SLOT_W-1:0] slot_q;
    logic              slot_end;

    // A slot ends on the last tick; the sequence ends on the last slot's end.
    assign slot_end = fast_en && (tick_q == TICK_LAST);
    assign seq_load = slot_end && (slot_q == SLOT_LAST);
    assign slot_idx = slot_q;

    // Count fast ticks within the current slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick_q <= TICK_LAST;
        else if (fast_en)
            tick_q <= slot_end ? '0 : tick_q + 1'b1;
    end

    // Step the slot index at each slot end and wrap at the sequence end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_q <= SLOT_LAST;
        else if (seq_load)
            slot_q <= '0;
        else if (slot_end)
            slot_q <= slot_q + 1'b1;
    end

    // Raise frame_start for the one clock that follows a sequence load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame_start <= 1'b0;
        else
            frame_start <= seq_load;
    end

endmodule

// File: rtl/dac_fine_mux.sv
// dac_fine_mux: picks the fine bit for the current slot, MSB first.
// Slot 0 carries the top fine bit and the last slot the lowest one.
module dac_fine_mux #(
    parameter int unsigned FINE_W = 4,
    parameter int unsigned SLOT_W = 2
) (
    input  logic [FINE_W-1:0] fine_code,
    input  logic [SLOT_W-1:0] slot_idx,
    output logic              fine_bit
);
    // Reverse-order selection of one fine bit per slot.
    always_comb begin
        fine_bit = 1'b0;
        for (int k = 0; k < int'(FINE_W); k++) begin
            if (slot_idx == SLOT_W'(k))
                fine_bit = fine_code[FINE_W-1-k];
        end
    end

endmodule

// File: rtl/dac_split_seq.sv
// dac_split_seq: top of the split-resolution DAC code sequencer.
// The coarse word is the upper part of the working code. The fine part is
// serialised one bit per slot. A channel of at most coarse resolution has no
// fine path. Assumes CODE_W > FINE_W >= 2 and COARSE_W <= RES_BITS <= CODE_W.
module dac_split_seq #(
    parameter int unsigned CODE_W         = 12,
    parameter int unsigned FINE_W         = 4,
    parameter int unsigned TICKS_PER_SLOT = 4,
    parameter int unsigned RES_BITS       = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_en,
    input  logic              wr_valid,
    input  logic [CODE_W-1:0] wr_code,
    output logic [CODE_W-FINE_W-1:0] coarse_word,
    output logic              fine_bit,
    output logic              frame_start
);
    localparam int unsigned COARSE_W = CODE_W - FINE_W;
    localparam int unsigned SLOT_W   = $clog2(FINE_W);

    logic [CODE_W-1:0] work_code;
    logic              seq_load;
    logic [SLOT_W-1:0] slot_idx;

    dac_code_regs #(
        .CODE_W   (CODE_W),
        .RES_BITS (RES_BITS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_code   (wr_code),
        .seq_load  (seq_load),
        .work_code (work_code)
    );

    dac_slot_timer #(
        .FINE_W         (FINE_W),
        .TICKS_PER_SLOT (TICKS_PER_SLOT),
        .SLOT_W         (SLOT_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .fast_en     (fast_en),
        .seq_load    (seq_load),
        .slot_idx    (slot_idx),
        .frame_start (frame_start)
    );

    // Coarse word goes straight from the working code.
    assign coarse_word = work_code[CODE_W-1 -: COARSE_W];

    // Fine path exists only when the channel resolves bits below the coarse word.
    generate
        if (RES_BITS > COARSE_W) begin : g_fine
            dac_fine_mux #(
                .FINE_W (FINE_W),
                .SLOT_W (SLOT_W)
            ) u_fine (
                .fine_code (work_code[FINE_W-1:0]),
                .slot_idx  (slot_idx),
                .fine_bit  (fine_bit)
            );
        end else begin : g_no_fine
            assign fine_bit = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/dac_split_seq_chk.sv
// dac_split_seq_chk: assertion checker for dac_split_seq, attached by bind.
// A tick counter measures the sequence length so that no deep $past is needed.
module dac_split_seq_chk #(
    parameter int unsigned CODE_W         = 12,
    parameter int unsigned FINE_W         = 4,
    parameter int unsigned TICKS_PER_SLOT = 4,
    parameter int unsigned RES_BITS       = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fast_en,
    input logic              wr_valid,
    input logic [CODE_W-1:0] wr_code,
    input logic [CODE_W-FINE_W-1:0] coarse_word,
    input logic              fine_bit,
    input logic              frame_start
);
    localparam int unsigned COARSE_W = CODE_W - FINE_W;
    localparam int unsigned SEQ_LEN  = FINE_W * TICKS_PER_SLOT;
    localparam int unsigned CNT_W    = $clog2(SEQ_LEN + 1) + 1;

    logic [CNT_W-1:0] tick_cnt;
    logic             seen_fs;

    // Count fast ticks since the last frame_start, that cycle included.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            seen_fs  <= 1'b0;
        end else if (frame_start) begin
            tick_cnt <= fast_en ? CNT_W'(1) : '0;
            seen_fs  <= 1'b1;
        end else if (fast_en && (tick_cnt <= CNT_W'(SEQ_LEN))) begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    assert_fs_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    assert_fs_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> $past(fast_en));

    assert_seq_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && seen_fs) |-> (tick_cnt == CNT_W'(SEQ_LEN)));

    assert_no_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
        seen_fs |-> (tick_cnt <= CNT_W'(SEQ_LEN)));

    assert_coarse_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |-> $stable(coarse_word));

    assert_fine_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !$past(fast_en)) |-> $stable(fine_bit));

    assert_boundary_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && $past(wr_valid)) |-> (coarse_word == $past(wr_code[CODE_W-1 -: COARSE_W])));

    generate
        if (RES_BITS <= COARSE_W) begin : g_chk_coarse_only
            assert_fine_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
                fine_bit == 1'b0);
        end
    endgenerate

endmodule

bind dac_split_seq dac_split_seq_chk #(
    .CODE_W         (CODE_W),
    .FINE_W         (FINE_W),
    .TICKS_PER_SLOT (TICKS_PER_SLOT),
    .RES_BITS       (RES_BITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fast_en     (fast_en),
    .wr_valid    (wr_valid),
    .wr_code     (wr_code),
    .coarse_word (coarse_word),
    .fine_bit    (fine_bit),
    .frame_start (frame_start)
);

// File: tb/dac_split_seq_tb_top.sv
// Scoreboard bench: driver tasks push the code each sequence should carry,
// and a monitor pops one at every frame_start and checks all slots.
module dac_split_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TPS        = 4;
    localparam int SEQ_TICKS  = 4 * TPS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_en = 1'b0;
    logic        run_fast = 1'b0;
    logic        wr_valid = 1'b0;
    logic [11:0] wr_code = '0;
    logic [7:0]  c12, c8, c10;
    logic        f12, f8, f10;
    logic        fs, fs8, fs10;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;
    int div = 0;

    logic [11:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_split_seq #(.RES_BITS(12), .TICKS_PER_SLOT(TPS)) dut_i (
        .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .wr_valid(wr_valid),
        .wr_code(wr_code), .coarse_word(c12), .fine_bit(f12), .frame_start(fs));
    dac_split_seq #(.RES_BITS(8), .TICKS_PER_SLOT(TPS)) dut8_i (
        .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .wr_valid(wr_valid),
        .wr_code(wr_code), .coarse_word(c8), .fine_bit(f8), .frame_start(fs8));
    dac_split_seq #(.RES_BITS(10), .TICKS_PER_SLOT(TPS)) dut10_i (
        .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .wr_valid(wr_valid),
        .wr_code(wr_code), .coarse_word(c10), .fine_bit(f10), .frame_start(fs10));

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, expv, $time);
        end
    endtask

    // Fast tick generator, one tick every TPS clocks, driven at negedge.
    always @(negedge clk) begin
        if (!run_fast) begin
            div = 0;
            fast_en = 1'b0;
        end else begin
            fast_en = (div == TPS - 1);
            div = (div == TPS - 1) ? 0 : div + 1;
        end
    end

    // Monitor: pops the expected code at each frame start, checks every cycle.
    logic [11:0] exp_code = '0;
    int  cnt = 0;
    bit  seen = 0;
    bit  prev_fs = 0;
    initial begin
        forever begin
            @(negedge clk); #1;
            if (rst_n && !done) begin
                if (fs) begin
                    check(!prev_fs, "R3 frame_start width", 1, 0);
                    if (seen) check(cnt == SEQ_TICKS, "R3 sequence length", cnt, SEQ_TICKS);
                    check(fs8 == fs && fs10 == fs, "R3 frame alignment", {fs8, fs10}, {fs, fs});
                    cnt = 0;
                    if (exp_q.size() > 0) exp_code = exp_q.pop_front();
                    seen = 1;
                end
                if (!seen) begin
                    check(c12 == 8'h00 && f12 == 1'b0 && fs == 1'b0, "R9 idle after reset",
                          {c12, f12, fs}, 0);
                end else begin
                    int slot;
                    slot = cnt / TPS;
                    check(c12 == exp_code[11:4], "R1 R4 R5 R7 coarse", c12, exp_code[11:4]);
                    check(f12 == exp_code[3 - slot], "R2 fine bit", f12, exp_code[3 - slot]);
                    check(c8 == exp_code[11:4] && f8 == 1'b0, "R8 8-bit channel",
                          {c8, f8}, {exp_code[11:4], 1'b0});
                    check(f10 == ((slot < 2) ? exp_code[3 - slot] : 1'b0), "R8 10-bit fine",
                          f10, (slot < 2) ? exp_code[3 - slot] : 1'b0);
                end
                if (fast_en) cnt++;
                prev_fs = fs;
            end
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic wait_fs();
        do step(); while (!fs);
    endtask

    task automatic pulse_write(input logic [11:0] code);
        wr_valid = 1'b1;
        wr_code  = code;
        step();
        wr_valid = 1'b0;
    endtask

    // Write in the middle of a sequence: applied at the next boundary (R4).
    task automatic write_mid(input logic [11:0] code);
        wait_fs();
        repeat (10) step();
        exp_q.push_back(code);
        pulse_write(code);
        repeat (3) step();
        check(c12 == exp_code[11:4], "R4 no mid-sequence change", c12, exp_code[11:4]);
    endtask

    // Two writes in one sequence: the last one wins (R5).
    task automatic write_two(input logic [11:0] a, input logic [11:0] b);
        wait_fs();
        repeat (5) step();
        pulse_write(a);
        repeat (5) step();
        exp_q.push_back(b);
        pulse_write(b);
        wait_fs();
        check(c12 == b[11:4], "R5 last write wins", c12, b[11:4]);
    endtask

    // Write on the boundary tick (R6) or one clock before it (late == 1).
    task automatic write_edge(input logic [11:0] code, input bit late);
        int n;
        wait_fs();
        n = 0;
        forever begin
            if (fast_en) n++;
            if (n == (late ? SEQ_TICKS - 1 : SEQ_TICKS)) break;
            step();
        end
        if (late) begin
            step();
            step();
            step();
        end
        exp_q.push_back(code);
        pulse_write(code);
        if (!late) begin
            check(fs == 1'b1, "R6 boundary frame_start", fs, 1);
            check(c12 == code[11:4], "R6 boundary write applied", c12, code[11:4]);
        end
    endtask

    initial begin
        wr_valid = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        check(c12 == 8'h00 && f12 == 1'b0 && fs == 1'b0, "R9 reset outputs", {c12, f12, fs}, 0);
        rst_n = 1'b1;
        run_fast = 1'b1;
        wait_fs();
        write_mid(12'h7FF);
        write_mid(12'h800);
        write_mid(12'hA5C);
        wait_fs();
        wait_fs();
        check(c12 == 8'hA5, "R7 code replayed", c12, 8'hA5);
        wait_fs();
        check(c12 == 8'hA5, "R7 code replayed again", c12, 8'hA5);
        write_two(12'h123, 12'h3F1);
        write_edge(12'h5A6, 1'b0);
        write_edge(12'h00F, 1'b1);
        write_edge(12'hFF0, 1'b0);
        write_mid(12'h000);
        wait_fs();
        wait_fs();
        check(c12 == 8'h00 && f12 == 1'b0, "R1 zero code", {c12, f12}, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule